// File: doc/BRIEF.md
# Subvector Swizzle Move Unit

This unit performs a component-reordering move on one subvector. A 12-bit swizzle immediate holds one 3-bit selector per destination component. The unit walks the destination components one per clock, from component 0 up to the subvector length minus one. For each component it either copies one of the source components, writes the constant 0.0, writes the constant 1.0, or leaves the destination component unchanged. The source read address is the element index times the subvector length plus the selector.

The register file is outside the unit. It is reached through a combinational read port (address out, data in during the same cycle) and a write port made of a strobe, a component number and 64-bit data. A pulse on `start` latches the immediate, the subvector length and the element index. `busy` covers the whole operation, and `done` pulses once after the last component. The loop over vector elements is driven from outside, one `start` per element.

Top module: `swizzle_move_unit`

## Requirements
- R1: After reset `busy`, `done` and `wrEn` are low, and they stay low until `start` is seen.
- R2: Destination component s takes its selector from swizzle bits [3s+2:3s].
- R3: A selector value v in 0..3 with v below the effective subvector length drives `rdAddr` = elemIdx*length + v and writes `rdData` to component s.
- R4: Selector value 4 writes 64'h0000000000000000 (double-precision 0.0).
- R5: Selector value 5 writes 64'h3FF0000000000000 (double-precision 1.0).
- R6: Selector values 6 and 7 leave `wrEn` low for that component.
- R7: A selector value in 0..3 that is not below the effective subvector length leaves `wrEn` low for that component.
- R8: Components are presented one per cycle in ascending order on `wrComp`. Component 0 appears in the cycle right after the edge that accepts `start`.
- R9: `done` is high for exactly one cycle, the cycle after the last component. `busy` is high from the accepting edge through that `done` cycle and low afterwards.
- R10: `start` is ignored while `busy` is high, and an operation in progress keeps its latched settings.
- R11: The effective length is `subVl` for values 1..4. A value of 0 counts as 1, and values 5..7 count as 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| swizzle | input | 12 | Four 3-bit selectors, component 0 in the low bits |
| subVl | input | 3 | Subvector length (1..4) |
| elemIdx | input | 6 | Current vector element index |
| rdAddr | output | 8 | Source component read address |
| rdData | input | 64 | Read data for `rdAddr`, same cycle |
| wrEn | output | 1 | Write strobe for the current component |
| wrComp | output | 2 | Destination component number |
| wrData | output | 64 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a `start` pulse that arrives in the middle of a run. If the unit reloaded its settings there, the fault would show only as a changed selector in a later component. The bench raises `start` with a different immediate, length and index during the first component of chosen runs. It then checks that the remaining components still follow the original settings. Directed cases also cover out-of-range selectors under short lengths and the clamped length codes 0 and 7, while seeded random runs mix all eight selector values.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int SEL_W = 3;
  localparam int MAX_COMPS = 4;
  localparam int SWZ_W = SEL_W * MAX_COMPS;
  localparam int COMP_W = $clog2(MAX_COMPS);
  localparam int LEN_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } swzState_t;

  typedef struct packed {
    logic load;
    logic step;
  } swzStrobes_t;

  function automatic logic [LEN_W-1:0] effLen(input logic [LEN_W-1:0] raw);
    if (raw == '0) return LEN_W'(1);
    if (raw > LEN_W'(MAX_COMPS)) return LEN_W'(MAX_COMPS);
    return raw;
  endfunction
endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isLast,
  output swzStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  swzState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes = '0;
    case (state)
      ST_IDLE: if (start) begin
        strobes.load = 1'b1;
        stateNext = ST_RUN;
      end
      ST_RUN: begin
        strobes.step = 1'b1;
        if (isLast) stateNext = ST_FIN;
      end
      ST_FIN: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);
endmodule

// File: rtl/swz_dpath.sv
module swz_dpath
  import swz_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int DATA_W = 64,
  parameter logic [DATA_W-1:0] CONST_ZERO = '0,
  parameter logic [DATA_W-1:0] CONST_ONE = 64'h3FF0_0000_0000_0000,
  localparam int ADDR_W = IDX_W + COMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  swzStrobes_t       strobes,
  input  logic [SWZ_W-1:0]  swizzle,
  input  logic [LEN_W-1:0]  subVl,
  input  logic [IDX_W-1:0]  elemIdx,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrEn,
  output logic [COMP_W-1:0] wrComp,
  output logic [DATA_W-1:0] wrData,
  output logic              isLast
);
  logic [SWZ_W-1:0]  swzR;
  logic [LEN_W-1:0]  lenR;
  logic [ADDR_W-1:0] baseR;
  logic [COMP_W-1:0] compR;
  logic [SEL_W-1:0]  fields [MAX_COMPS];
  logic [SEL_W-1:0]  sel;
  logic              doWrite;
  logic [LEN_W-1:0]  lenIn;

  assign lenIn = effLen(subVl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swzR  <= '0;
      lenR  <= LEN_W'(1);
      baseR <= '0;
      compR <= '0;
    end else if (strobes.load) begin
      swzR  <= swizzle;
      lenR  <= lenIn;
      baseR <= ADDR_W'(elemIdx) * ADDR_W'(lenIn);
      compR <= '0;
    end else if (strobes.step) begin
      compR <= compR + COMP_W'(1);
    end
  end

  for (genvar g = 0; g < MAX_COMPS; g++) begin : g_field
    assign fields[g] = swzR[g*SEL_W +: SEL_W];
  end

  assign sel    = fields[compR];
  assign rdAddr = baseR + ADDR_W'(sel[1:0]);
  assign isLast = (LEN_W'(compR) == lenR - LEN_W'(1));
  assign wrComp = compR;

  always_comb begin
    doWrite = 1'b0;
    wrData  = rdData;
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: doWrite = (LEN_W'(sel) < lenR);
      3'd4: begin doWrite = 1'b1; wrData = CONST_ZERO; end
      3'd5: begin doWrite = 1'b1; wrData = CONST_ONE; end
      default: doWrite = 1'b0;
    endcase
  end

  assign wrEn = strobes.step & doWrite;
endmodule

// File: rtl/swizzle_move_unit.sv
module swizzle_move_unit
  import swz_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [SWZ_W-1:0]          swizzle,
  input  logic [LEN_W-1:0]          subVl,
  input  logic [IDX_W-1:0]          elemIdx,
  output logic [IDX_W+COMP_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]         rdData,
  output logic                      wrEn,
  output logic [COMP_W-1:0]         wrComp,
  output logic [DATA_W-1:0]         wrData,
  output logic                      busy,
  output logic                      done
);
  swzStrobes_t strobes;
  logic        isLast;

  swz_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isLast(isLast),
    .strobes(strobes), .busy(busy), .done(done)
  );

  swz_dpath #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .swizzle(swizzle),
    .subVl(subVl), .elemIdx(elemIdx), .rdData(rdData), .rdAddr(rdAddr),
    .wrEn(wrEn), .wrComp(wrComp), .wrData(wrData), .isLast(isLast)
  );
endmodule

// File: rtl/swizzle_move_unit_chk.sv
module swizzle_move_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrComp,
  input logic       busy,
  input logic       done
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!wrEn && !done));

  p_first_comp_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (wrComp == 2'd0));

  p_step_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && $past(busy) && !$past(done) && $past(rstN))
      |-> (wrComp == $past(wrComp) + 2'd1));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
endmodule

bind swizzle_move_unit swizzle_move_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrComp(wrComp),
  .busy(busy), .done(done)
);

// File: tb/sim_swizzle_move_unit.sv
module sim_swizzle_move_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] swizzle = '0;
  logic [2:0]  subVl = 3'd1;
  logic [5:0]  elemIdx = '0;
  logic [7:0]  rdAddr;
  logic [63:0] rdData;
  logic        wrEn;
  logic [1:0]  wrComp;
  logic [63:0] wrData;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [63:0] srcVal(input logic [7:0] a);
    return {24'hA5C3E1, a, 24'h0F1E2D ^ {16'h0, a}, a ^ 8'h5A};
  endfunction

  assign rdData = srcVal(rdAddr);

  swizzle_move_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .swizzle(swizzle), .subVl(subVl),
    .elemIdx(elemIdx), .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn),
    .wrComp(wrComp), .wrData(wrData), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [2:0] raw);
    if (raw == 0) return 1;
    if (raw > 4) return 4;
    return int'(raw);
  endfunction

  task automatic runOp(input logic [11:0] swz, input logic [2:0] len,
                       input logic [5:0] idx, input bit poke);
    int eff = lenOf(len);
    @(negedge clk);
    swizzle = swz; subVl = len; elemIdx = idx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < eff; c++) begin
      int f = int'(swz[3*c +: 3]);
      bit expEn;
      logic [63:0] expData;
      logic [7:0] expAddr;
      string tag;
      expAddr = 8'(int'(idx) * eff + (f & 3));
      expEn = 1'b0; expData = '0;
      if (f < 4) begin
        tag = (f < eff) ? "R3" : "R7";
        expEn = (f < eff);
        expData = srcVal(expAddr);
      end else if (f == 4) begin
        tag = "R4"; expEn = 1'b1; expData = 64'h0;
      end else if (f == 5) begin
        tag = "R5"; expEn = 1'b1; expData = 64'h3FF0_0000_0000_0000;
      end else tag = "R6";
      check(busy && !done && wrComp == 2'(c), "R8 order", {62'h0, wrComp}, 64'(c));
      check(wrEn == expEn, tag, {63'h0, wrEn}, {63'h0, expEn});
      if (expEn) check(wrData == expData, tag, wrData, expData);
      if (expEn && f < 4) check(rdAddr == expAddr, "R3 addr", {56'h0, rdAddr}, {56'h0, expAddr});
      if (poke && c == 0) begin
        // R10: a fresh start mid-run must not disturb the operation
        swizzle = ~swz; subVl = 3'd2; elemIdx = idx + 6'd9; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(done && busy && !wrEn, "R9 done", {62'h0, done, busy}, 64'h3);
    @(negedge clk);
    check(!done && !busy && !wrEn, "R9 release", {61'h0, done, busy, wrEn}, 64'h0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(!busy && !done && !wrEn, "R1 reset", {61'h0, busy, done, wrEn}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wrEn, "R1 idle", {61'h0, busy, done, wrEn}, 64'h0);
    // R2: reversal proves per-component field positions
    runOp(12'o0123, 3'd4, 6'd5, 1'b0);
    runOp(12'o7654, 3'd4, 6'd1, 1'b0);   // R4 R5 R6
    runOp(12'o0032, 3'd2, 6'd7, 1'b0);   // R7 out-of-range selectors
    runOp(12'o3210, 3'd3, 6'd63, 1'b0);  // R3 top index
    runOp(12'o7771, 3'd0, 6'd4, 1'b0);   // R11 length 0 acts as 1
    runOp(12'o3210, 3'd7, 6'd2, 1'b0);   // R11 length 7 acts as 4
    runOp(12'o2301, 3'd4, 6'd3, 1'b1);   // R10 start while busy
    for (int k = 0; k < 60; k++) begin
      runOp(12'($urandom), 3'($urandom_range(0, 7)), 6'($urandom), ($urandom % 4) == 0);
    end
    repeat (3) begin
      @(negedge clk);
      check(!busy && !wrEn, "R1 stays idle", {62'h0, busy, wrEn}, 64'h0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule